// File: doc/BRIEF.md
# Single-wire HDQ bus master

This block is a master for a single-wire, HDQ-style serial bus. It sits behind a small byte-wide register window. Software loads a data byte, then writes the control/status register to start one of three operations. The first drives a long low break pulse that resets the slave. The second shifts a byte out least-significant bit first. The third collects a byte that the slave sends. Each operation raises a completion flag in an interrupt status register. That register is cleared by reading it.

The wire itself is open-drain. The block only pulls it low, through an output-enable, and it watches the line through a separate input. All bit-slot timing is set by parameters counted in functional-clock cycles: the break low and recovery times, the bit period, the low times for a one and for a zero, the sample point in a received bit, and a read time-out window.

A completion only takes full effect while the interrupt-enable bit is set. While that bit is clear, the GO and INIT bits stay at one, and reading the status does not clear the flags. A soft reset can be started from the system configuration register. It returns every register to its default, and its progress can be read in the system status register.

Top module: `hdq_master`

## Requirements
- R1: After reset, the registers read as follows: control/status (offset 0x0C) reads 0x00, interrupt status (0x10) reads 0x00, system config (0x14) reads 0x00, system status (0x18) reads 0x01 and revision (0x00) reads 0x12. The outputs line_oe and irq are 0.
- R2: Writing control/status with GO (bit 4) = 1 and DIR (bit 1) = 0 sends the byte held at offset 0x04 least-significant bit first. Each bit slot lasts BIT_CYCLES and begins with a low pulse of exactly ONE_LOW cycles for a 1 or ZERO_LOW cycles for a 0. When the byte is done, TX complete (interrupt status bit 2) is set.
- R3: Writing GO = 1 with DIR = 1 receives 8 bits, least-significant first. Each bit is the line level SAMPLE_AT cycles after a falling edge driven by the slave. The master never drives the line during a read. The byte then reads at offset 0x08, and RX complete (bit 1) is set.
- R4: In a read, if no falling edge arrives within READ_TIMEOUT cycles of the start or of the previous sample, the timeout flag (bit 0) is set instead of RX complete, and GO returns to 0.
- R5: Writing INIT (bit 2) and GO together drives the line low for exactly BREAK_LOW cycles, then releases it for BREAK_REC cycles. After that the timeout flag (bit 0) is set, and INIT and GO read 0.
- R6: irq equals interrupt enable (bit 6) ANDed with the OR of the three flags. With interrupt enable set, reading offset 0x10 returns the flags and clears them.
- R7: With interrupt enable clear, GO stays 1 after an operation completes, and reading interrupt status does not clear it. Once interrupt enable is set, GO clears.
- R8: While GO is 1, writes to TX data are ignored. Writes to control/status change only bit 6 (interrupt enable).
- R9: Writing system config with bit 1 set starts a soft reset. For SRST_CYCLES cycles, system status bit 0 reads 0, the bus is released and the registers hold their defaults. After that, system status bit 0 reads 1 and all registers read their defaults. Bit 0 of system config is stored and read back only.
- R10: The clock-enable (bit 5) and MODE (bit 0) bits are stored and read back. line_oe is 0 whenever GO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-on-read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| line_oe | output | 1 | Pull the bus low when 1 |
| line_in | input | 1 | Level seen on the bus |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends all 256 byte values and decodes each low-pulse width on the wire. A bit-order or width mix-up shows up as a wrong decoded byte or a width mismatch. Received bytes include all-zero and all-one patterns. A read is also cut short after three bits; a design that sampled at the wrong offset, or had no time-out, would return bad data or hang with GO stuck at 1. The bench covers several edge cases:
- completion with interrupt enable clear, where a design that cleared GO or the flags anyway would break R7;
- attempts to change TX data and DIR in mid-transfer;
- a soft reset in the middle of a transfer, which must release the wire at once and leave no flag set.

// File: rtl/hdq_pkg.sv
package hdq_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_REV   = 5'h00;
    localparam logic [ADDR_W-1:0] A_TX    = 5'h04;
    localparam logic [ADDR_W-1:0] A_RX    = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_INT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_SCFG  = 5'h14;
    localparam logic [ADDR_W-1:0] A_SSTAT = 5'h18;

    localparam int C_IEN   = 6;
    localparam int C_CLKEN = 5;
    localparam int C_GO    = 4;
    localparam int C_INIT  = 2;
    localparam int C_DIR   = 1;
    localparam int C_MODE  = 0;

    localparam int F_TX  = 2;
    localparam int F_RX  = 1;
    localparam int F_TMO = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK_LO,
        ST_BRK_REC,
        ST_TX_BIT,
        ST_RX_WAIT,
        ST_RX_SAMP
    } eng_state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_TX,
        END_RX,
        END_TMO
    } end_kind_e;
endpackage

// File: rtl/hdq_engine.sv
module hdq_engine
    import hdq_pkg::*;
#(
    parameter int BREAK_LOW    = 40,
    parameter int BREAK_REC    = 20,
    parameter int BIT_CYCLES   = 30,
    parameter int ONE_LOW      = 5,
    parameter int ZERO_LOW     = 20,
    parameter int SAMPLE_AT    = 12,
    parameter int READ_TIMEOUT = 60
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      start,
    input  logic      start_brk,
    input  logic      start_rd,
    input  logic [7:0] tx_byte,
    input  logic      line_in,
    output logic      line_oe,
    output logic      done,
    output end_kind_e done_kind,
    output logic [7:0] rx_byte
);
    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAXT = max2(max2(max2(BREAK_LOW, BREAK_REC), max2(BIT_CYCLES, READ_TIMEOUT)),
                               max2(max2(ONE_LOW, ZERO_LOW), SAMPLE_AT));
    localparam int CW = $clog2(MAXT + 1);

    localparam logic [CW-1:0] T_BRKL = CW'(BREAK_LOW - 1);
    localparam logic [CW-1:0] T_BRKR = CW'(BREAK_REC - 1);
    localparam logic [CW-1:0] T_BIT  = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] T_SMP  = CW'(SAMPLE_AT - 1);
    localparam logic [CW-1:0] T_RTO  = CW'(READ_TIMEOUT - 1);
    localparam logic [CW-1:0] T_W1   = CW'(ONE_LOW);
    localparam logic [CW-1:0] T_W0   = CW'(ZERO_LOW);

    typedef struct packed {
        eng_state_e st;
        logic [CW-1:0] cnt;
        logic [2:0] bitn;
        logic [7:0] sh;
        logic prev_in;
        logic done;
        end_kind_e kind;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        eng_d.done = 1'b0;
        eng_d.kind = END_NONE;
        eng_d.prev_in = line_in;
        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.cnt = '0;
                    eng_d.bitn = '0;
                    if (start_brk) begin
                        eng_d.st = ST_BRK_LO;
                    end else if (start_rd) begin
                        eng_d.st = ST_RX_WAIT;
                        eng_d.sh = '0;
                    end else begin
                        eng_d.st = ST_TX_BIT;
                        eng_d.sh = tx_byte;
                    end
                end
            end
            ST_BRK_LO: begin
                if (eng_q.cnt == T_BRKL) begin
                    eng_d.st = ST_BRK_REC;
                    eng_d.cnt = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ST_BRK_REC: begin
                if (eng_q.cnt == T_BRKR) begin
                    eng_d.st = ST_IDLE;
                    eng_d.done = 1'b1;
                    eng_d.kind = END_TMO;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ST_TX_BIT: begin
                if (eng_q.cnt == T_BIT) begin
                    eng_d.cnt = '0;
                    eng_d.sh = {1'b0, eng_q.sh[7:1]};
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    if (eng_q.bitn == 3'd7) begin
                        eng_d.st = ST_IDLE;
                        eng_d.done = 1'b1;
                        eng_d.kind = END_TX;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ST_RX_WAIT: begin
                if (eng_q.prev_in && !line_in) begin
                    eng_d.st = ST_RX_SAMP;
                    eng_d.cnt = '0;
                end else if (eng_q.cnt == T_RTO) begin
                    eng_d.st = ST_IDLE;
                    eng_d.done = 1'b1;
                    eng_d.kind = END_TMO;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ST_RX_SAMP: begin
                if (eng_q.cnt == T_SMP) begin
                    eng_d.sh = {line_in, eng_q.sh[7:1]};
                    eng_d.bitn = eng_q.bitn + 1'b1;
                    eng_d.cnt = '0;
                    if (eng_q.bitn == 3'd7) begin
                        eng_d.st = ST_IDLE;
                        eng_d.done = 1'b1;
                        eng_d.kind = END_RX;
                    end else begin
                        eng_d.st = ST_RX_WAIT;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        if (clr) begin
            eng_d = '0;
            eng_d.st = ST_IDLE;
            eng_d.kind = END_NONE;
            eng_d.prev_in = line_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
            eng_q.prev_in <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign line_oe = (eng_q.st == ST_BRK_LO) ||
                     ((eng_q.st == ST_TX_BIT) && (eng_q.cnt < (eng_q.sh[0] ? T_W1 : T_W0)));
    assign done = eng_q.done;
    assign done_kind = eng_q.kind;
    assign rx_byte = eng_q.sh;
endmodule

// File: rtl/hdq_regs.sv
module hdq_regs
    import hdq_pkg::*;
#(
    parameter int REV_MAJOR   = 1,
    parameter int REV_MINOR   = 2,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              eng_done,
    input  end_kind_e         eng_kind,
    input  logic [7:0]        eng_rx,
    output logic              start,
    output logic              start_brk,
    output logic              start_rd,
    output logic [7:0]        tx_byte,
    output logic              go,
    output logic              ien,
    output logic              irq,
    output logic              srst_any,
    output logic              srst_busy
);
    localparam int SW = $clog2(SRST_CYCLES + 1);
    localparam logic [SW-1:0] T_SRST = SW'(SRST_CYCLES - 1);

    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] rx;
        logic ien;
        logic clken;
        logic go;
        logic init;
        logic dir;
        logic mode;
        logic [2:0] flags;
        logic fin;
        logic autoidle;
        logic srst;
        logic [SW-1:0] scnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        start = 1'b0;
        start_brk = wdata[C_INIT];
        start_rd = wdata[C_DIR];
        if (r_q.srst) begin
            r_d = '0;
            if (r_q.scnt != T_SRST) begin
                r_d.srst = 1'b1;
                r_d.scnt = r_q.scnt + 1'b1;
            end
        end else begin
            if (rd_en && addr == A_INT && r_q.ien) begin
                r_d.flags = '0;
            end
            if (r_q.fin && r_q.ien) begin
                r_d.go = 1'b0;
                r_d.init = 1'b0;
                r_d.fin = 1'b0;
            end
            if (eng_done) begin
                r_d.fin = 1'b1;
                case (eng_kind)
                    END_TX:  r_d.flags[F_TX] = 1'b1;
                    END_RX: begin
                        r_d.flags[F_RX] = 1'b1;
                        r_d.rx = eng_rx;
                    end
                    END_TMO: r_d.flags[F_TMO] = 1'b1;
                    default: ;
                endcase
            end
            if (wr_en) begin
                case (addr)
                    A_TX: if (!r_q.go) r_d.tx = wdata;
                    A_CTRL: begin
                        if (!r_q.go) begin
                            r_d.ien   = wdata[C_IEN];
                            r_d.clken = wdata[C_CLKEN];
                            r_d.go    = wdata[C_GO];
                            r_d.init  = wdata[C_INIT];
                            r_d.dir   = wdata[C_DIR];
                            r_d.mode  = wdata[C_MODE];
                            start     = wdata[C_GO];
                        end else begin
                            r_d.ien = wdata[C_IEN];
                        end
                    end
                    A_SCFG: begin
                        r_d.autoidle = wdata[0];
                        if (wdata[1]) begin
                            r_d = '0;
                            r_d.srst = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_REV:   rdata = {4'(REV_MAJOR), 4'(REV_MINOR)};
            A_TX:    rdata = r_q.tx;
            A_RX:    rdata = r_q.rx;
            A_CTRL:  rdata = {1'b0, r_q.ien, r_q.clken, r_q.go, 1'b0, r_q.init, r_q.dir, r_q.mode};
            A_INT:   rdata = {5'b0, r_q.flags};
            A_SCFG:  rdata = {6'b0, r_q.srst, r_q.autoidle};
            A_SSTAT: rdata = {7'b0, ~r_q.srst};
            default: rdata = 8'h00;
        endcase
    end

    assign tx_byte   = r_q.tx;
    assign go        = r_q.go;
    assign ien       = r_q.ien;
    assign irq       = r_q.ien && (|r_q.flags);
    assign srst_busy = r_q.srst;
    assign srst_any  = r_q.srst || (wr_en && addr == A_SCFG && wdata[1]);
endmodule

// File: rtl/hdq_master.sv
module hdq_master
    import hdq_pkg::*;
#(
    parameter int REV_MAJOR    = 1,
    parameter int REV_MINOR    = 2,
    parameter int SRST_CYCLES  = 4,
    parameter int BREAK_LOW    = 40,
    parameter int BREAK_REC    = 20,
    parameter int BIT_CYCLES   = 30,
    parameter int ONE_LOW      = 5,
    parameter int ZERO_LOW     = 20,
    parameter int SAMPLE_AT    = 12,
    parameter int READ_TIMEOUT = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       line_oe,
    input  logic       line_in,
    output logic       irq
);
    logic       start_w, start_brk_w, start_rd_w;
    logic [7:0] tx_w, rx_w;
    logic       go_w, ien_w, srst_any_w, srst_q_w;
    logic       done_w;
    end_kind_e  kind_w;
    logic       tx_wr_w;

    assign tx_wr_w = reg_wr && (reg_addr == A_TX);

    hdq_regs #(
        .REV_MAJOR  (REV_MAJOR),
        .REV_MINOR  (REV_MINOR),
        .SRST_CYCLES(SRST_CYCLES)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .eng_done (done_w),
        .eng_kind (kind_w),
        .eng_rx   (rx_w),
        .start    (start_w),
        .start_brk(start_brk_w),
        .start_rd (start_rd_w),
        .tx_byte  (tx_w),
        .go       (go_w),
        .ien      (ien_w),
        .irq      (irq),
        .srst_any (srst_any_w),
        .srst_busy(srst_q_w)
    );

    hdq_engine #(
        .BREAK_LOW   (BREAK_LOW),
        .BREAK_REC   (BREAK_REC),
        .BIT_CYCLES  (BIT_CYCLES),
        .ONE_LOW     (ONE_LOW),
        .ZERO_LOW    (ZERO_LOW),
        .SAMPLE_AT   (SAMPLE_AT),
        .READ_TIMEOUT(READ_TIMEOUT)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (srst_any_w),
        .start    (start_w),
        .start_brk(start_brk_w),
        .start_rd (start_rd_w),
        .tx_byte  (tx_w),
        .line_in  (line_in),
        .line_oe  (line_oe),
        .done     (done_w),
        .done_kind(kind_w),
        .rx_byte  (rx_w)
    );
endmodule

// File: rtl/hdq_master_chk.sv
module hdq_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_oe,
    input logic       irq,
    input logic       go,
    input logic       ien,
    input logic       srst_any,
    input logic       srst_q,
    input logic       tx_wr,
    input logic [7:0] tx_q
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !go |-> !line_oe); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ien |-> !irq); // R6
    AST_GO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (go && !ien && !srst_any) |=> go); // R7
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n) (go && tx_wr && !srst_any) |=> $stable(tx_q)); // R8
    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) srst_q |-> (!go && !irq && !line_oe)); // R9
endmodule

bind hdq_master hdq_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_oe (line_oe),
    .irq     (irq),
    .go      (go_w),
    .ien     (ien_w),
    .srst_any(srst_any_w),
    .srst_q  (srst_q_w),
    .tx_wr   (tx_wr_w),
    .tx_q    (tx_w)
);

// File: tb/hdq_master_tb.sv
module hdq_master_tb_top;
    localparam int BRKL = 40;
    localparam int BRKR = 20;
    localparam int BITC = 30;
    localparam int W1   = 5;
    localparam int W0   = 20;
    localparam int SMP  = 12;
    localparam int RTO  = 60;
    localparam int SRSTC = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic [4:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       line_oe, irq;
    logic       slave_pull;
    logic       line_in;

    assign line_in = ~line_oe & ~slave_pull;

    hdq_master #(
        .REV_MAJOR(1), .REV_MINOR(2), .SRST_CYCLES(SRSTC),
        .BREAK_LOW(BRKL), .BREAK_REC(BRKR), .BIT_CYCLES(BITC),
        .ONE_LOW(W1), .ZERO_LOW(W0), .SAMPLE_AT(SMP), .READ_TIMEOUT(RTO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr_en), .reg_rd(rd_en),
        .reg_wdata(wdata), .reg_rdata(rdata), .line_oe(line_oe), .line_in(line_in), .irq(irq)
    );

    int checks = 0;
    int fails = 0;

    int low_run = 0;
    int last_low = 0;
    logic [7:0] mon_byte = 8'h00;
    int mon_bits = 0;
    bit mon_en = 1'b0;
    int bad_w = 0;
    bit rx_watch = 1'b0;
    int oe_in_rx = 0;
    logic mon_b;

    always @(posedge clk) begin
        if (rx_watch && line_oe) oe_in_rx++;
        if (line_oe) begin
            low_run++;
        end else if (low_run != 0) begin
            last_low = low_run;
            if (mon_en) begin
                mon_b = (low_run < (W1 + W0) / 2);
                mon_byte = {mon_b, mon_byte[7:1]};
                mon_bits++;
                if (low_run != (mon_b ? W1 : W0)) bad_w++;
            end
            low_run = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        int n;
        n = 0;
        do begin
            rd(5'h0C, v);
            n++;
        end while (v[4] && n < 2000);
        chk(req, int'(v[4]), 0);
    endtask

    task automatic slave_send(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            repeat (16) @(negedge clk);
            slave_pull = 1'b1;
            repeat (b[i] ? 4 : 25) @(negedge clk);
            slave_pull = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; slave_pull = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 line_oe", int'(line_oe), 0);
        chk("R1 irq", int'(irq), 0);
        rd(5'h0C, v); chk("R1 ctrl", v, 8'h00);
        rd(5'h10, v); chk("R1 intstat", v, 8'h00);
        rd(5'h14, v); chk("R1 sysconfig", v, 8'h00);
        rd(5'h18, v); chk("R1 sysstatus", v, 8'h01);
        rd(5'h00, v); chk("R1 revision", v, 8'h12);

        // R2 exhaustive transmit sweep
        for (int k = 0; k < 256; k++) begin
            b = 8'(k);
            wr(5'h04, b);
            mon_bits = 0;
            mon_en = 1'b1;
            wr(5'h0C, 8'h70);
            if (b == 8'hA5) begin
                wr(5'h04, 8'h3C);          // R8 ignored while busy
                wr(5'h0C, 8'h72);          // R8 only bit 6 may change
                rd(5'h04, v); chk("R8 tx held", v, 8'hA5);
                rd(5'h0C, v); chk("R8 ctrl held", v, 8'h70);
            end
            wait_idle("R2 go clears");
            mon_en = 1'b0;
            chk("R2 byte on wire", mon_byte, b);
            chk("R2 bit count", mon_bits, 8);
            chk("R6 irq raised", int'(irq), 1);
            rd(5'h10, v); chk("R2 tx flag", v, 8'h04);
            rd(5'h10, v); chk("R6 cleared on read", v, 8'h00);
            chk("R6 irq dropped", int'(irq), 0);
            chk("R10 released", int'(line_oe), 0);
        end
        chk("R2 pulse widths", bad_w, 0);

        // R3 receive patterns
        for (int k = 0; k < 32; k++) begin
            b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + 5) % 256);
            oe_in_rx = 0;
            rx_watch = 1'b1;
            wr(5'h0C, 8'h72);
            slave_send(b, 8);
            wait_idle("R3 go clears");
            rx_watch = 1'b0;
            rd(5'h08, v); chk("R3 rx byte", v, b);
            rd(5'h10, v); chk("R3 rx flag", v, 8'h02);
            chk("R3 master silent", oe_in_rx, 0);
        end

        // R4 time-out with no slave, and after a partial byte
        wr(5'h0C, 8'h72);
        wait_idle("R4 go clears idle line");
        rd(5'h10, v); chk("R4 timeout flag idle line", v, 8'h01);
        wr(5'h0C, 8'h72);
        slave_send(8'h5A, 3);
        wait_idle("R4 go clears partial");
        rd(5'h10, v); chk("R4 timeout flag partial", v, 8'h01);

        // R5 break
        last_low = 0;
        wr(5'h0C, 8'h74);
        wait_idle("R5 go clears");
        chk("R5 break width", last_low, BRKL);
        rd(5'h10, v); chk("R5 timeout flag", v, 8'h01);
        rd(5'h0C, v); chk("R5 init and go clear", v, 8'h60);

        // R7 completion with interrupt enable clear
        wr(5'h04, 8'h96);
        mon_bits = 0;
        mon_en = 1'b1;
        wr(5'h0C, 8'h30);
        repeat (BITC * 8 + 60) @(negedge clk);
        mon_en = 1'b0;
        chk("R2 byte with ien off", mon_byte, 8'h96);
        rd(5'h0C, v); chk("R7 go held", v, 8'h30);
        chk("R6 irq gated", int'(irq), 0);
        rd(5'h10, v); chk("R7 flag visible", v, 8'h04);
        rd(5'h10, v); chk("R7 not cleared", v, 8'h04);
        wr(5'h0C, 8'h40);
        repeat (3) @(negedge clk);
        rd(5'h0C, v); chk("R7 go clears after ien", v, 8'h60);
        chk("R6 irq after ien", int'(irq), 1);
        rd(5'h10, v); chk("R6 read flag", v, 8'h04);
        rd(5'h10, v); chk("R6 read cleared", v, 8'h00);

        // R10 stored bits, R9 soft reset
        wr(5'h0C, 8'h61);
        rd(5'h0C, v); chk("R10 clken and mode stored", v, 8'h61);
        wr(5'h04, 8'hA5);
        wr(5'h14, 8'h01);
        rd(5'h14, v); chk("R9 autoidle stored", v, 8'h01);
        wr(5'h14, 8'h02);
        rd(5'h18, v); chk("R9 reset in progress", v, 8'h00);
        repeat (SRSTC + 4) @(negedge clk);
        rd(5'h18, v); chk("R9 reset done", v, 8'h01);
        rd(5'h0C, v); chk("R9 ctrl default", v, 8'h00);
        rd(5'h04, v); chk("R9 tx default", v, 8'h00);
        rd(5'h14, v); chk("R9 sysconfig default", v, 8'h00);

        // R9 soft reset aborting a transfer
        wr(5'h04, 8'h00);
        wr(5'h0C, 8'h70);
        repeat (BITC + 3) @(negedge clk);
        wr(5'h14, 8'h02);
        chk("R9 line released", int'(line_oe), 0);
        repeat (SRSTC + 4) @(negedge clk);
        repeat (BITC * 8) @(negedge clk);
        chk("R9 no irq after abort", int'(irq), 0);
        rd(5'h10, v); chk("R9 no flag after abort", v, 8'h00);
        rd(5'h0C, v); chk("R9 ctrl after abort", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule